// File: doc/BRIEF.md
# Code entry checker with timed indicators

This block walks a user through entering a four-digit binary code. Each digit is one bit of an 8-bit input word, and each digit has its own entry step. After the fourth step a check step compares the captured digits against an all-ones code. The block then lights an accepted or rejected indicator on a 3-bit LED output. Each indicator is held for a whole number of seconds, and then the block returns to the first entry step.

The length of every step comes from a single down-counter. The counter is loaded with the cycle count of the step being entered and is decremented on every clock. The clock frequency, the hold times in seconds and the length of the entry and check steps are all parameters, so a simulation can use a small clock rate and short holds.

Top module: `keycode_checker`

## Requirements
- R1: While reset is high, and on the first clock after reset is released, the LED reads 100 (entry mode). Reset is asynchronous. A reset during an indicator hold returns the block to the first entry step at once.
- R2: LED encoding: 100 during the four entry steps and the check step, 010 while the accepted indicator is held, 001 while the rejected indicator is held. Exactly one LED bit is high outside reset.
- R3: The four digits are taken from input bits 7, 6, 5 and 3, in that order. Each digit is sampled on the last clock of its own entry step. Input bits 4, 2, 1 and 0, and any value a tapped bit holds earlier in its step, have no effect on the outcome.
- R4: The check step selects the accepted indicator when all four captured digits are 1, and the rejected indicator in every other case.
- R5: The accepted indicator lasts exactly PASS_SECS*CLK_HZ clock cycles. After that the LED returns to 100 and a new entry round starts.
- R6: The rejected indicator lasts exactly FAIL_SECS*CLK_HZ clock cycles. After that the LED returns to 100 and a new entry round starts.
- R7: Each entry step and the check step lasts exactly STEP_CYCLES clock cycles.
- R8: The step counter never holds zero after reset. The step advances only on a clock where the counter holds 1, and on that clock the counter is reloaded with the cycle count of the new step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| din | input | 8 | Input word; bits 7, 6, 5 and 3 carry the code digits |
| led | output | 3 | Indicator: 100 entry, 010 accepted, 001 rejected |

## Verification
The assertions assume that reset is held for at least one clock edge. They also assume that the parameters give every step a count of at least one cycle, so the down-counter is never reloaded with zero.

The stimulus changes the input word and the reset only on falling clock edges, well away from the sampling edge. Within each entry step it first drives the opposite of the intended digit and sets the correct digit only for the final cycle. It fills the untapped bits with changing patterns so that sampling at the wrong moment or at the wrong position shows up in the outcome.

// File: rtl/keycode_pkg.sv
package keycode_pkg;

  typedef enum logic [2:0] {
    ST_CAP0  = 3'd0,
    ST_CAP1  = 3'd1,
    ST_CAP2  = 3'd2,
    ST_CAP3  = 3'd3,
    ST_CHECK = 3'd4,
    ST_PASS  = 3'd5,
    ST_FAIL  = 3'd6
  } kc_state_e;

  localparam int unsigned DIGITS = 4;

  // input bit position sampled in each capture step
  function automatic logic [2:0] tap_of(kc_state_e s);
    case (s)
      ST_CAP0: return 3'd7;
      ST_CAP1: return 3'd6;
      ST_CAP2: return 3'd5;
      default: return 3'd3;
    endcase
  endfunction

  function automatic logic is_capture(kc_state_e s);
    return (s == ST_CAP0) || (s == ST_CAP1) || (s == ST_CAP2) || (s == ST_CAP3);
  endfunction

  function automatic logic [2:0] led_code(kc_state_e s);
    case (s)
      ST_PASS: return 3'b010;
      ST_FAIL: return 3'b001;
      default: return 3'b100;
    endcase
  endfunction

  function automatic kc_state_e next_state(kc_state_e s, logic [DIGITS-1:0] dig);
    case (s)
      ST_CAP0:  return ST_CAP1;
      ST_CAP1:  return ST_CAP2;
      ST_CAP2:  return ST_CAP3;
      ST_CAP3:  return ST_CHECK;
      ST_CHECK: return (&dig) ? ST_PASS : ST_FAIL;
      default:  return ST_CAP0;
    endcase
  endfunction

  function automatic int unsigned hold_cycles(kc_state_e s, int unsigned step,
                                              int unsigned pass_c, int unsigned fail_c);
    case (s)
      ST_PASS: return pass_c;
      ST_FAIL: return fail_c;
      default: return step;
    endcase
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/kc_step_timer.sv
module kc_step_timer #(
  parameter int unsigned     CNT_W   = 8,
  parameter logic [CNT_W-1:0] RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] next_val,
  output logic             step_done,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;

  assign step_done = (cnt_q == CNT_W'(1));
  assign cnt       = cnt_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)            cnt_q <= RST_VAL;
    else if (step_done) cnt_q <= next_val;
    else                cnt_q <= cnt_q - CNT_W'(1);
  end

  // R8
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q != '0);

  // R8
  reload_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    step_done |-> (next_val != '0));

endmodule

// File: rtl/kc_entry_fsm.sv
module kc_entry_fsm
  import keycode_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step_done,
  input  logic [DATA_W-1:0]   din,
  output kc_state_e           state,
  output kc_state_e           state_nxt,
  output logic [DIGITS-1:0]   digits
);

  kc_state_e         state_q;
  logic [DIGITS-1:0] dig_q;
  logic              sel_bit;

  assign sel_bit   = din[tap_of(state_q)];
  assign state_nxt = next_state(state_q, dig_q);
  assign state     = state_q;
  assign digits    = dig_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)            state_q <= ST_CAP0;
    else if (step_done) state_q <= state_nxt;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) dig_q <= '0;
    else if (step_done && is_capture(state_q)) dig_q[state_q[1:0]] <= sel_bit;
  end

  // R8
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    !step_done |=> $stable(state_q));

  // R4
  accept_chk: assert property (@(posedge clk) disable iff (rst)
    (step_done && state_q == ST_CHECK && (&dig_q)) |=> state_q == ST_PASS);

  // R4
  reject_chk: assert property (@(posedge clk) disable iff (rst)
    (step_done && state_q == ST_CHECK && !(&dig_q)) |=> state_q == ST_FAIL);

  // R5
  return_chk: assert property (@(posedge clk) disable iff (rst)
    (step_done && (state_q == ST_PASS || state_q == ST_FAIL)) |=> state_q == ST_CAP0);

  // R3
  digits_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !step_done |=> $stable(dig_q));

endmodule

// File: rtl/keycode_checker.sv
module keycode_checker
  import keycode_pkg::*;
#(
  parameter int unsigned CLK_HZ      = 50_000_000,
  parameter int unsigned PASS_SECS   = 3,
  parameter int unsigned FAIL_SECS   = 2,
  parameter int unsigned STEP_CYCLES = 1,
  parameter int unsigned DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  output logic [2:0]        led
);

  localparam int unsigned PASS_CYC = PASS_SECS * CLK_HZ;
  localparam int unsigned FAIL_CYC = FAIL_SECS * CLK_HZ;
  localparam int unsigned MAX_CYC  = max3(PASS_CYC, FAIL_CYC, STEP_CYCLES);
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  kc_state_e         state, state_nxt;
  logic [DIGITS-1:0] digits;
  logic              step_done;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  reload;

  assign reload = CNT_W'(hold_cycles(state_nxt, STEP_CYCLES, PASS_CYC, FAIL_CYC));

  kc_step_timer #(
    .CNT_W   (CNT_W),
    .RST_VAL (CNT_W'(STEP_CYCLES))
  ) i_timer (
    .clk       (clk),
    .rst       (rst),
    .next_val  (reload),
    .step_done (step_done),
    .cnt       (cnt)
  );

  kc_entry_fsm #(
    .DATA_W (DATA_W)
  ) i_fsm (
    .clk       (clk),
    .rst       (rst),
    .step_done (step_done),
    .din       (din),
    .state     (state),
    .state_nxt (state_nxt),
    .digits    (digits)
  );

  assign led = led_code(state);

  // R2
  led_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(led) == 1);

  // R8
  reload_value_chk: assert property (@(posedge clk) disable iff (rst)
    step_done |=> cnt == CNT_W'(hold_cycles(state, STEP_CYCLES, PASS_CYC, FAIL_CYC)));

  // R7
  step_len_chk: assert property (@(posedge clk) disable iff (rst)
    (is_capture(state) || state == ST_CHECK) |-> cnt <= CNT_W'(STEP_CYCLES));

  // R2
  led_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (step_done && state == ST_CHECK && (&digits)) |=> led == 3'b010);

endmodule

// File: tb/test_keycode_checker.sv
module test_keycode_checker;

  localparam int unsigned HZ   = 8;
  localparam int unsigned STEP = 2;
  localparam int unsigned PASS_N = 3 * HZ;
  localparam int unsigned FAIL_N = 2 * HZ;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = 8'h00;
  logic [2:0] led;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  keycode_checker #(
    .CLK_HZ      (HZ),
    .PASS_SECS   (3),
    .FAIL_SECS   (2),
    .STEP_CYCLES (STEP),
    .DATA_W      (8)
  ) i_keycode_checker (
    .clk (clk),
    .rst (rst),
    .din (din),
    .led (led)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one entry round from a fresh first entry step; code[k] is digit k (bits 7,6,5,3)
  task automatic run_round(input logic [3:0] code, input logic [7:0] noise, input string tag);
    int taps[4] = '{7, 6, 5, 3};
    logic [2:0] exp_led;
    int unsigned exp_n;
    int unsigned n;
    bit early_ok;
    exp_led = (&code) ? 3'b010 : 3'b001;
    exp_n   = (&code) ? PASS_N : FAIL_N;
    early_ok = 1;
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < int'(STEP); c++) begin
        din = noise ^ 8'(k * 37 + c * 11);
        din[taps[k]] = (c == int'(STEP) - 1) ? code[k] : ~code[k];
        tick();
        if (led != 3'b100) early_ok = 0;
      end
    end
    chk(early_ok, {"R2 entry LED ", tag}, 0, 1);
    for (int c = 0; c < int'(STEP); c++) begin
      din = ~din;
      tick();
      if (c < int'(STEP) - 1) chk(led == 3'b100, {"R7 check step length ", tag}, led, 3'b100);
    end
    chk(led == exp_led, {"R4 outcome ", tag}, led, exp_led);
    n = 1;
    while (led == exp_led && n < exp_n + 8) begin
      din = din + 8'd3;
      tick();
      if (led == exp_led) n++;
    end
    if (&code) chk(n == PASS_N, {"R5 accept hold ", tag}, n, PASS_N);
    else       chk(n == FAIL_N, {"R6 reject hold ", tag}, n, FAIL_N);
    chk(led == 3'b100, {"R5 return to entry ", tag}, led, 3'b100);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(led == 3'b100, "R1 LED in reset", led, 3'b100);
    rst = 1'b0;
    tick();
    chk(led == 3'b100, "R1 LED after reset release", led, 3'b100);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_mid_hold();
    din = 8'hFF;
    repeat (5 * STEP + 3) tick();
    chk(led == 3'b010, "R5 accepted before reset", led, 3'b010);
    rst = 1'b1;
    #1;
    chk(led == 3'b100, "R1 asynchronous reset during hold", led, 3'b100);
    @(negedge clk);
    rst = 1'b0;
    run_round(4'b1111, 8'h00, "after mid-hold reset");
  endtask

  initial begin
    t_reset();
    run_round(4'b1111, 8'h00, "all ones quiet");
    run_round(4'b1111, 8'hFF, "R3 all ones noisy");
    run_round(4'b1110, 8'hFF, "R3 digit0 low");
    run_round(4'b1101, 8'h5A, "R3 digit1 low");
    run_round(4'b1011, 8'hA5, "R3 digit2 low");
    run_round(4'b0111, 8'h17, "R3 digit3 low");
    run_round(4'b0000, 8'hFF, "R3 untapped bits high");
    run_round(4'b1111, 8'h3C, "R8 back to back");
    t_reset_mid_hold();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 20000 && !done) begin
      done = 1;
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule